// File: doc/BRIEF.md
# Stop Mode Wake Controller

This block manages the deepest low-power state of a small microcontroller. When the CPU strobes a stop request, the block checks that the watchdog control register has been written since the last exit. If it has, the block turns off both the main and the sub oscillator enables and holds the system clock. If it has not, the block refuses to stop and raises an internal reset request instead. While stopped, it watches the wake sources: external interrupt pins, externally clocked serial and timer interrupts, the key-input interrupt and the reset pin. It accepts only the interrupt wakes that firmware has set up correctly.

After a qualified wake, the block restarts the oscillators that were running before the stop. It pulses a preset strobe that forces the timer mode registers used for stabilization to fixed values. It then counts out the oscillator settling interval before it releases the system clock. One cycle after the release, it hands the waking interrupt back to the CPU.

At stop entry the block also records two things as status. One is whether a stabilization-timer interrupt enable was left set. The other is whether the display drive was still enabled.

Top module: `stop_wake_ctrl`

## Requirements
- R1: A `stp_req` pulse while running, with the watchdog-written flag set, enters stop at the next clock edge. While stopped, `main_osc_en`, `sub_osc_en` and `clk_release` are all 0.
- R2: A `stp_req` pulse while running, with the watchdog-written flag clear, gives a one-cycle `int_rst_req` at the next edge, and the block keeps running. A `wdt_wr` pulse sets the flag. Each stop exit and `rst_n` clear it. A write in the same cycle as the request does not count for that request.
- R3: Source bit layout, with E = NUM_EXT: bits 0..E-1 are the external pins, E and E+1 are the serial interrupts, E+2 and E+3 are the timer interrupts, and E+4 is the key input. A source wakes the block only when all of these hold: `irq_mask_all` is 0, its `irq_en` bit is 1, its `irq_req` bit was 0 at stop entry and is now 1, and, for a pin or key source, its direction bit is 0.
- R4: Request activity that fails any condition of R3 leaves the block stopped, with the clock held and both oscillator enables at 0.
- R5: An interrupt wake gives exactly one `tmr_preset` pulse, in the first stabilization cycle. A reset-pin wake gives none.
- R6: During stabilization after an interrupt wake, `sub_osc_en` equals `sub_run` as captured at stop entry. `main_osc_en` is 1 if the main oscillator was running or was the selected system clock at entry.
- R7: If the wake is seen at edge W, `clk_release` rises at edge W+L. L is STAB_MAIN (8192) when the main oscillator was the system clock at entry, and STAB_SUB (16) otherwise.
- R8: After an interrupt wake, `wake_fwd` is high for exactly one cycle, at edge W+L+1. `wake_vec` then holds the sources that caused the wake.
- R9: The reset pin wakes a stopped block with priority over interrupts, always with L = STAB_MAIN. It restores the default oscillator context (main on, sub off, main selected) and clears `cfg_err` and `lcd_dc_warn`. It gives no `wake_fwd`.
- R10: `cfg_err` becomes 1 when stop is entered with either `tmr12_ie` bit set. It then stays 1 until a reset-pin wake or `rst_n`.
- R11: `lcd_dc_warn` shows the value of `lcd_en` at the most recent stop entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (the active oscillator) |
| rst_n | input | 1 | Asynchronous active-low reset |
| stp_req | input | 1 | CPU stop strobe |
| wdt_wr | input | 1 | Watchdog control register was written |
| irq_req | input | NUM_EXT+5 | Interrupt request bits |
| irq_en | input | NUM_EXT+5 | Interrupt enable bits |
| irq_mask_all | input | 1 | Global interrupt disable flag |
| tmr12_ie | input | 2 | Interrupt enables of the two stabilization timers |
| dir_ext | input | NUM_EXT | Direction bits of external interrupt pins (1 = output) |
| dir_key | input | 1 | Direction bit of the key-input port (1 = output) |
| main_run | input | 1 | Main oscillator running (clock-select state) |
| sub_run | input | 1 | Sub oscillator running (clock-select state) |
| sel_main | input | 1 | Main oscillator is the system clock |
| lcd_en | input | 1 | Display drive enable bit |
| rst_pin | input | 1 | Reset input used as a wake source |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Sub oscillator enable |
| clk_release | output | 1 | System clock released to the CPU |
| tmr_preset | output | 1 | One-cycle timer mode register preset |
| wake_fwd | output | 1 | Wake interrupt handed back to the CPU |
| wake_vec | output | NUM_EXT+5 | Sources that caused the last interrupt wake |
| int_rst_req | output | 1 | Internal reset request |
| cfg_err | output | 1 | Sticky stabilization-timer enable error |
| lcd_dc_warn | output | 1 | Display drive was enabled at stop entry |

## Verification
The bench tries each way a wake can fail to qualify: a disabled source, a pin set as an output, a request already pending at entry, and the global mask. A design that ignores any one of these wakes up early. Those requests are still asserted when the mask drops, and the release time is checked against the real wake edge, so a controller that latched a stale request would miss that timing. The bench also waits out the full 8192-cycle interval for a main-clock wake and for a reset-pin wake made with the sub clock selected. A design that picked the wrong length, or forwarded an interrupt or fired a preset on reset wake, produces events at the wrong cycle or events that should not exist. Finally, a second stop is attempted without a fresh watchdog write, which exposes a flag that is not cleared on exit.

// File: rtl/stopwake_pkg.sv
package stopwake_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_STAB = 2'd2,
    ST_REL  = 2'd3
  } sw_state_e;

  typedef struct packed {
    logic main_on;
    logic sub_on;
    logic sel_main;
  } osc_ctx_t;

  localparam osc_ctx_t CTX_DEFAULT = '{main_on: 1'b1, sub_on: 1'b0, sel_main: 1'b1};

  function automatic osc_ctx_t capture_ctx(logic main_run, logic sub_run, logic sel_main);
    osc_ctx_t c;
    c.main_on  = main_run;
    c.sub_on   = sub_run;
    c.sel_main = sel_main;
    return c;
  endfunction

endpackage

// File: rtl/sw_wake_qual.sv
module sw_wake_qual #(
  parameter int NUM_EXT = 4,
  localparam int NUM_SRC = NUM_EXT + 5
) (
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] snap,
  input  logic [NUM_SRC-1:0] en,
  input  logic [NUM_EXT-1:0] dir_ext,
  input  logic               dir_key,
  input  logic               mask_all,
  output logic [NUM_SRC-1:0] hit_vec,
  output logic               hit
);

  logic [NUM_SRC-1:0] pin_ok;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pin
    if (i < NUM_EXT) begin : g_ext
      assign pin_ok[i] = ~dir_ext[i];
    end else if (i == NUM_SRC - 1) begin : g_key
      assign pin_ok[i] = ~dir_key;
    end else begin : g_int
      assign pin_ok[i] = 1'b1;
    end
  end

  function automatic logic [NUM_SRC-1:0] qualify(
    logic [NUM_SRC-1:0] r, logic [NUM_SRC-1:0] s,
    logic [NUM_SRC-1:0] e, logic [NUM_SRC-1:0] p, logic m);
    if (m) return '0;
    return r & ~s & e & p;
  endfunction

  assign hit_vec = qualify(req, snap, en, pin_ok, mask_all);
  assign hit     = |hit_vec;

endmodule

// File: rtl/sw_stab_timer.sv
module sw_stab_timer #(
  parameter int MAIN_LEN = 8192,
  parameter int SUB_LEN  = 16,
  localparam int CW = (MAIN_LEN > 2) ? $clog2(MAIN_LEN) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic use_main,
  input  logic run,
  output logic done
);

  localparam logic [CW-1:0] MAIN_LAST = CW'(MAIN_LEN - 1);
  localparam logic [CW-1:0] SUB_LAST  = CW'(SUB_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_q;

  function automatic logic [CW-1:0] pick_last(logic m);
    return m ? MAIN_LAST : SUB_LAST;
  endfunction

  assign done = run && (cnt_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= MAIN_LAST;
    end else if (load) begin
      cnt_q  <= '0;
      last_q <= pick_last(use_main);
    end else if (run && !done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sw_ctx_hold.sv
module sw_ctx_hold import stopwake_pkg::*; #(
  parameter int NUM_SRC = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enter,
  input  logic               rst_wake,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               main_run,
  input  logic               sub_run,
  input  logic               sel_main,
  input  logic               lcd_en,
  input  logic [1:0]         tmr12_ie,
  output logic [NUM_SRC-1:0] snap,
  output osc_ctx_t           ctx,
  output logic               lcd_flag,
  output logic               cfg_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap     <= '0;
      ctx      <= CTX_DEFAULT;
      lcd_flag <= 1'b0;
      cfg_err  <= 1'b0;
    end else if (enter) begin
      snap     <= irq_req;
      ctx      <= capture_ctx(main_run, sub_run, sel_main);
      lcd_flag <= lcd_en;
      cfg_err  <= cfg_err | (|tmr12_ie);
    end else if (rst_wake) begin
      ctx      <= CTX_DEFAULT;
      lcd_flag <= 1'b0;
      cfg_err  <= 1'b0;
    end
  end

endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl import stopwake_pkg::*; #(
  parameter int NUM_EXT   = 4,
  parameter int STAB_MAIN = 8192,
  parameter int STAB_SUB  = 16,
  localparam int NUM_SRC  = NUM_EXT + 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stp_req,
  input  logic               wdt_wr,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_SRC-1:0] irq_en,
  input  logic               irq_mask_all,
  input  logic [1:0]         tmr12_ie,
  input  logic [NUM_EXT-1:0] dir_ext,
  input  logic               dir_key,
  input  logic               main_run,
  input  logic               sub_run,
  input  logic               sel_main,
  input  logic               lcd_en,
  input  logic               rst_pin,
  output logic               main_osc_en,
  output logic               sub_osc_en,
  output logic               clk_release,
  output logic               tmr_preset,
  output logic               wake_fwd,
  output logic [NUM_SRC-1:0] wake_vec,
  output logic               int_rst_req,
  output logic               cfg_err,
  output logic               lcd_dc_warn
);

  sw_state_e state_q, state_d;

  logic               wdt_seen_q, rel_ph_q, from_irq_q, preset_q, deny_q;
  logic [NUM_SRC-1:0] vec_q, snap, hit_vec;
  logic               hit, stab_done;
  osc_ctx_t           ctx;

  logic in_run, in_stop, in_stab, in_rel;
  logic stop_go, stop_deny, rst_wake, irq_wake, wake_any, rel_exit;

  assign in_run    = (state_q == ST_RUN);
  assign in_stop   = (state_q == ST_STOP);
  assign in_stab   = (state_q == ST_STAB);
  assign in_rel    = (state_q == ST_REL);
  assign stop_go   = in_run && stp_req && wdt_seen_q;
  assign stop_deny = in_run && stp_req && !wdt_seen_q;
  assign rst_wake  = in_stop && rst_pin;
  assign irq_wake  = in_stop && !rst_pin && hit;
  assign wake_any  = rst_wake || irq_wake;
  assign rel_exit  = in_rel && rel_ph_q;

  sw_wake_qual #(.NUM_EXT(NUM_EXT)) u_qual (
    .req      (irq_req),
    .snap     (snap),
    .en       (irq_en),
    .dir_ext  (dir_ext),
    .dir_key  (dir_key),
    .mask_all (irq_mask_all),
    .hit_vec  (hit_vec),
    .hit      (hit)
  );

  sw_ctx_hold #(.NUM_SRC(NUM_SRC)) u_ctx (
    .clk      (clk),
    .rst_n    (rst_n),
    .enter    (stop_go),
    .rst_wake (rst_wake),
    .irq_req  (irq_req),
    .main_run (main_run),
    .sub_run  (sub_run),
    .sel_main (sel_main),
    .lcd_en   (lcd_en),
    .tmr12_ie (tmr12_ie),
    .snap     (snap),
    .ctx      (ctx),
    .lcd_flag (lcd_dc_warn),
    .cfg_err  (cfg_err)
  );

  sw_stab_timer #(.MAIN_LEN(STAB_MAIN), .SUB_LEN(STAB_SUB)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wake_any),
    .use_main (rst_wake || ctx.sel_main),
    .run      (in_stab),
    .done     (stab_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (stop_go)   state_d = ST_STOP;
      ST_STOP: if (wake_any)  state_d = ST_STAB;
      ST_STAB: if (stab_done) state_d = ST_REL;
      ST_REL:  if (rel_ph_q)  state_d = ST_RUN;
      default:                state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      wdt_seen_q <= 1'b0;
      rel_ph_q   <= 1'b0;
      from_irq_q <= 1'b0;
      preset_q   <= 1'b0;
      deny_q     <= 1'b0;
      vec_q      <= '0;
    end else begin
      state_q  <= state_d;
      preset_q <= irq_wake;
      deny_q   <= stop_deny;
      rel_ph_q <= in_rel && !rel_ph_q;
      if (rel_exit)    wdt_seen_q <= 1'b0;
      else if (wdt_wr) wdt_seen_q <= 1'b1;
      if (wake_any) from_irq_q <= irq_wake;
      if (irq_wake) vec_q      <= hit_vec;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_RUN: begin
        main_osc_en = main_run;
        sub_osc_en  = sub_run;
      end
      ST_STOP: begin
        main_osc_en = 1'b0;
        sub_osc_en  = 1'b0;
      end
      default: begin
        main_osc_en = ctx.main_on | ctx.sel_main;
        sub_osc_en  = ctx.sub_on;
      end
    endcase
  end

  assign clk_release = in_run || in_rel;
  assign tmr_preset  = preset_q;
  assign wake_fwd    = rel_exit && from_irq_q;
  assign wake_vec    = vec_q;
  assign int_rst_req = deny_q;

endmodule

// File: rtl/sw_checker.sv
module sw_checker (
  input logic clk,
  input logic rst_n,
  input logic stopped,
  input logic stabilizing,
  input logic main_osc_en,
  input logic sub_osc_en,
  input logic clk_release,
  input logic tmr_preset,
  input logic wake_fwd,
  input logic int_rst_req
);

  AST_OSC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> (!main_osc_en && !sub_osc_en)); // R1

  AST_CLK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped || stabilizing) |-> !clk_release); // R7

  AST_PRESET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_preset |=> !tmr_preset); // R5

  AST_PRESET_AT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_preset |-> (stabilizing && $past(stopped))); // R5

  AST_DENY_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst_req |-> (!stopped && clk_release)); // R2

  AST_FWD_AFTER_REL: assert property (@(posedge clk) disable iff (!rst_n)
    wake_fwd |-> (clk_release && $past(clk_release))); // R8

  AST_FWD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_fwd |=> !wake_fwd); // R8

endmodule

bind stop_wake_ctrl sw_checker u_sw_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stopped     (in_stop),
  .stabilizing (in_stab),
  .main_osc_en (main_osc_en),
  .sub_osc_en  (sub_osc_en),
  .clk_release (clk_release),
  .tmr_preset  (tmr_preset),
  .wake_fwd    (wake_fwd),
  .int_rst_req (int_rst_req)
);

// File: tb/stop_wake_ctrl_test.sv
module stop_wake_ctrl_test;
  localparam int NE = 4;
  localparam int NS = NE + 5;
  localparam int LM = 8192;
  localparam int LS = 16;
  localparam int K_PRESET = 0, K_REL = 1, K_FWD = 2, K_RST = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stp_req = 0, wdt_wr = 0, irq_mask_all = 0, dir_key = 0;
  logic main_run = 1, sub_run = 1, sel_main = 1, lcd_en = 0, rst_pin = 0;
  logic [NS-1:0] irq_req = '0, irq_en = '0;
  logic [1:0] tmr12_ie = '0;
  logic [NE-1:0] dir_ext = '0;
  logic main_osc_en, sub_osc_en, clk_release, tmr_preset, wake_fwd, int_rst_req, cfg_err, lcd_dc_warn;
  logic [NS-1:0] wake_vec;

  stop_wake_ctrl #(.NUM_EXT(NE), .STAB_MAIN(LM), .STAB_SUB(LS)) uut (.*);

  always #10 clk = ~clk;

  int cyc = 0, n_checks = 0, n_fail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int kind; int at; } exp_t;
  exp_t q[$];
  logic prev_rel = 1'b1;

  function automatic string kreq(int k);
    case (k)
      K_PRESET: return "R5";
      K_REL:    return "R7";
      K_FWD:    return "R8";
      default:  return "R2";
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic push(int kind, int at);
    exp_t e;
    e.kind = kind;
    e.at = at;
    q.push_back(e);
  endtask

  task automatic observe(int kind);
    exp_t e;
    if (q.size() == 0) begin
      check(0, kreq(kind), kind, -1);
    end else begin
      e = q.pop_front();
      check(e.kind == kind && e.at == cyc, kreq(e.kind), kind * 100000 + cyc, e.kind * 100000 + e.at);
    end
  endtask

  // monitor: sample between edges, compare each event with the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (tmr_preset) observe(K_PRESET);
      if (clk_release && !prev_rel) observe(K_REL);
      if (wake_fwd) observe(K_FWD);
      if (int_rst_req) observe(K_RST);
      prev_rel = clk_release;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_stop();
    @(negedge clk); stp_req = 1;
    @(negedge clk); stp_req = 0;
  endtask

  task automatic wdt_write();
    @(negedge clk); wdt_wr = 1;
    @(negedge clk); wdt_wr = 0;
  endtask

  // called at the negedge whose stimulus produces the wake; posedge cyc+1 sees it
  task automatic expect_wake(int len, bit by_irq);
    if (by_irq) push(K_PRESET, cyc + 1);
    push(K_REL, cyc + 1 + len);
    if (by_irq) push(K_FWD, cyc + 2 + len);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R7", 0, 1);
    summary();
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // reset state
    check(clk_release == 1 && tmr_preset == 0 && wake_fwd == 0, "R1", clk_release, 1);
    check(int_rst_req == 0 && cfg_err == 0 && lcd_dc_warn == 0, "R2", int_rst_req, 0);
    check(main_osc_en == 1 && sub_osc_en == 1, "R6", {main_osc_en, sub_osc_en}, 3);

    // R2: stop without watchdog write is refused
    @(negedge clk); stp_req = 1; push(K_RST, cyc + 1);
    @(negedge clk); stp_req = 0;
    tick(2);
    check(clk_release == 1 && main_osc_en == 1, "R2", clk_release, 1);

    // sub clock selected, pin 0 wake later
    wdt_write();
    sel_main = 0; main_run = 0; sub_run = 1; lcd_en = 1; irq_en = 9'h007;
    do_stop();
    check(main_osc_en == 0 && sub_osc_en == 0 && clk_release == 0, "R1",
          {main_osc_en, sub_osc_en, clk_release}, 0);
    check(lcd_dc_warn == 1, "R11", lcd_dc_warn, 1);
    check(cfg_err == 0, "R10", cfg_err, 0);
    // R4: disabled source, output-direction pin, globally masked request
    @(negedge clk); irq_req[3] = 1;
    tick(3);
    @(negedge clk); dir_ext[2] = 1; irq_req[2] = 1;
    tick(3);
    @(negedge clk); irq_mask_all = 1; irq_req[0] = 1;
    tick(3);
    check(clk_release == 0 && main_osc_en == 0 && sub_osc_en == 0, "R4",
          {main_osc_en, sub_osc_en, clk_release}, 0);
    // R3: unmask with request pending -> wake on pin 0 only
    @(negedge clk); irq_mask_all = 0; expect_wake(LS, 1);
    tick(2);
    check(main_osc_en == 0 && sub_osc_en == 1, "R6", {main_osc_en, sub_osc_en}, 1);
    tick(LS + 3);
    check(wake_vec == 9'h001, "R3", wake_vec, 1);
    check(clk_release == 1, "R8", clk_release, 1);
    irq_req = '0; dir_ext = '0; irq_en = '0;

    // R2: flag cleared by the exit, second stop refused
    @(negedge clk); stp_req = 1; push(K_RST, cyc + 1);
    @(negedge clk); stp_req = 0;
    tick(2);

    // main clock, timer enable error, pending request at entry, key wake
    wdt_write();
    sel_main = 1; main_run = 1; sub_run = 1; lcd_en = 0; tmr12_ie = 2'b01;
    irq_en = 9'h120; irq_req[5] = 1;
    do_stop();
    tmr12_ie = 2'b00;
    check(cfg_err == 1, "R10", cfg_err, 1);
    check(lcd_dc_warn == 0, "R11", lcd_dc_warn, 0);
    tick(4);
    check(clk_release == 0, "R4", clk_release, 0);
    @(negedge clk); irq_req[8] = 1; expect_wake(LM, 1);
    tick(2);
    check(main_osc_en == 1 && sub_osc_en == 1, "R6", {main_osc_en, sub_osc_en}, 3);
    tick(LM + 3);
    check(wake_vec == 9'h100, "R8", wake_vec, 256);
    check(cfg_err == 1, "R10", cfg_err, 1);
    irq_req = '0;

    // R9: reset pin wake with sub clock selected, same-cycle interrupt
    wdt_write();
    sel_main = 0; main_run = 0; sub_run = 1; lcd_en = 1; irq_en = 9'h001;
    do_stop();
    check(lcd_dc_warn == 1, "R11", lcd_dc_warn, 1);
    @(negedge clk); rst_pin = 1; irq_req[0] = 1; expect_wake(LM, 0);
    @(negedge clk); rst_pin = 0;
    check(main_osc_en == 1 && sub_osc_en == 0, "R9", {main_osc_en, sub_osc_en}, 2);
    check(cfg_err == 0 && lcd_dc_warn == 0, "R9", {cfg_err, lcd_dc_warn}, 0);
    tick(LM + 4);
    check(clk_release == 1, "R9", clk_release, 1);
    check(wake_vec == 9'h100, "R9", wake_vec, 256);
    irq_req = '0;

    tick(4);
    check(q.size() == 0, "R7", q.size(), 0);
    summary();
    $finish;
  end

endmodule